// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This unit derives the four interrupt sources of a synchronous serial port from the occupancy of its receive and transmit FIFOs. It also watches a frame-complete strobe, a receive-FIFO read strobe and a bit-period tick. Software sees the sources through a small register port with four registers:

| Address | Access | Register |
|---|---|---|
| 0 | read/write | Enable mask |
| 1 | read only | Unmasked status |
| 2 | read only | Enabled status |
| 3 | write only | Clear-on-write-one for the two latched sources |

A single interrupt request line goes to the system interrupt controller.

The FIFO storage and the shift engine sit outside the block. The block only sees their status. It also returns a replace strobe that tells the receive FIFO to overwrite its newest entry when a frame lands on a full FIFO.

Top module: `sport_irq_unit`

## Requirements
- R1: Status and mask bits use a fixed order. Bit 0 is receive overrun, bit 1 is receive timeout, bit 2 is receive half full and bit 3 is transmit half empty. Data bits 7:4 always read as zero, and address 3 reads as zero.
- R2: After reset, with an empty transmit FIFO, the mask reads 0x00, the unmasked status reads 0x08, the enabled status reads 0x00 and irq_o is low.
- R3: When rx_frame_i is high while rx_level_i equals the receive depth, rx_replace_o is high in that same cycle, and status bit 0 is set from the next cycle.
- R4: Status bit 1 sets on the 32nd bit_tick_i counted with a non-empty receive FIFO. A receive read or a received frame restarts the count, and an empty receive FIFO holds the count at zero.
- R5: Status bit 2 is high whenever rx_level_i is at least half the receive depth.
- R6: Status bit 3 is high whenever at least half of the transmit FIFO is free.
- R7: Status bits 0 and 1 stay set until a 1 is written to the same bit at address 3. Writing 0 there has no effect. A set and a clear in the same cycle leave the bit set.
- R8: Address 0 holds a 4-bit enable mask that is written from data bits 3:0.
- R9: Address 2 reads the unmasked status ANDed bit by bit with the mask.
- R10: irq_o equals the OR of the enabled status bits, delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | $clog2(RX_DEPTH+1) | Receive FIFO occupancy |
| tx_level_i | input | $clog2(TX_DEPTH+1) | Transmit FIFO occupancy |
| rx_frame_i | input | 1 | A complete frame was received this cycle |
| rx_pop_i | input | 1 | Receive FIFO read this cycle |
| bit_tick_i | input | 1 | One pulse per bit period |
| rx_replace_o | output | 1 | Overwrite newest receive entry with the incoming frame |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- rx_frame_i is a single-cycle strobe that is sampled together with the occupancy the FIFO had before the frame.
- The occupancy inputs never exceed their depths.
- rx_pop_i only comes while the receive FIFO is non-empty.

The stimulus holds the levels steady between steps and never drives a count above its depth. It pulses the strobes for exactly one clock and only reads from a non-empty FIFO model.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;
  localparam int NUM_SRC    = 4;
  localparam int NUM_STICKY = 2;
  localparam int DW         = 8;

  localparam int SRC_OVR = 0;
  localparam int SRC_TMO = 1;
  localparam int SRC_RXH = 2;
  localparam int SRC_TXH = 3;

  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_RAW  = 2'd1,
    ADDR_MIS  = 2'd2,
    ADDR_CLR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sport_level_flags.sv
module sport_level_flags #(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  localparam int RXW = $clog2(RX_DEPTH + 1),
  localparam int TXW = $clog2(TX_DEPTH + 1)
) (
  input  logic [RXW-1:0] rx_level_i,
  input  logic [TXW-1:0] tx_level_i,
  output logic           rx_full_o,
  output logic           rx_half_o,
  output logic           tx_half_o
);
  localparam logic [RXW-1:0] RX_FULL_LVL = RXW'(RX_DEPTH);
  localparam logic [RXW-1:0] RX_HALF_LVL = RXW'(RX_DEPTH / 2);
  // free slots >= depth/2  <=>  level <= depth - depth/2
  localparam logic [TXW-1:0] TX_MAX_LVL  = TXW'(TX_DEPTH - TX_DEPTH / 2);

  assign rx_full_o = (rx_level_i == RX_FULL_LVL);
  assign rx_half_o = (rx_level_i >= RX_HALF_LVL);
  assign tx_half_o = (tx_level_i <= TX_MAX_LVL);
endmodule

// File: rtl/sport_rx_timeout.sv
module sport_rx_timeout #(
  parameter int TICKS = 32,
  localparam int CW = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_empty_i,
  input  logic rx_frame_i,
  input  logic rx_pop_i,
  input  logic bit_tick_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);
  localparam logic [CW-1:0] LAST  = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          restart;

  assign restart = rx_empty_i | rx_frame_i | rx_pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (restart)                    cnt_q <= '0;
    else if (bit_tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  // one pulse on the tick that completes the period; saturated count stays quiet
  assign expire_o = !restart && bit_tick_i && (cnt_q == LAST);

  // R4
  tmo_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i |=> (cnt_q == '0));
  // R4
  tmo_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  // R4
  tmo_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i || rx_frame_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sport_irq_regs.sv
module sport_irq_regs
  import sport_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovr_set_i,
  input  logic          tmo_set_i,
  input  logic          rx_half_i,
  input  logic          tx_half_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [NUM_STICKY-1:0] sticky_q, sticky_set, sticky_clr;
  logic [NUM_SRC-1:0]    mask_q, raw, masked;
  logic                  irq_q;
  logic                  wr_mask, wr_clr;
  logic                  unused_wdata;

  assign wr_mask = reg_wr_i && (reg_addr_i == ADDR_MASK);
  assign wr_clr  = reg_wr_i && (reg_addr_i == ADDR_CLR);

  assign sticky_set = {tmo_set_i, ovr_set_i};
  assign sticky_clr = wr_clr ? reg_wdata_i[NUM_STICKY-1:0] : '0;

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sticky_q[i] <= 1'b0;
      else         sticky_q[i] <= sticky_set[i] | (sticky_q[i] & ~sticky_clr[i]);
    end

    // R7
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_q[i] && !sticky_clr[i]) |=> sticky_q[i]);
    // R7
    sticky_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_clr && reg_wdata_i[i] && !sticky_set[i]) |=> !sticky_q[i]);
    // R3 R4
    sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sticky_set[i] |=> sticky_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i[NUM_SRC-1:0];
  end

  always_comb begin
    raw          = '0;
    raw[SRC_OVR] = sticky_q[0];
    raw[SRC_TMO] = sticky_q[1];
    raw[SRC_RXH] = rx_half_i;
    raw[SRC_TXH] = tx_half_i;
  end

  assign masked = raw & mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked;
  end
  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_MASK: reg_rdata_o[NUM_SRC-1:0] = mask_q;
      ADDR_RAW:  reg_rdata_o[NUM_SRC-1:0] = raw;
      ADDR_MIS:  reg_rdata_o[NUM_SRC-1:0] = masked;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign unused_wdata = ^reg_wdata_i[DW-1:NUM_SRC];

  // R10
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|masked) |=> irq_o);
  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|masked) |=> !irq_o);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DW-1:NUM_SRC] == '0);
  // R8
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_q == $past(reg_wdata_i[NUM_SRC-1:0])));
endmodule

// File: rtl/sport_irq_unit.sv
module sport_irq_unit
  import sport_irq_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int TMO_TICKS = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [$clog2(RX_DEPTH+1)-1:0]   rx_level_i,
  input  logic [$clog2(TX_DEPTH+1)-1:0]   tx_level_i,
  input  logic                            rx_frame_i,
  input  logic                            rx_pop_i,
  input  logic                            bit_tick_i,
  output logic                            rx_replace_o,
  input  logic                            reg_wr_i,
  input  logic [1:0]                      reg_addr_i,
  input  logic [7:0]                      reg_wdata_i,
  output logic [7:0]                      reg_rdata_o,
  output logic                            irq_o
);
  logic rx_full, rx_half, tx_half, rx_empty, tmo_expire, ovr_set;

  sport_level_flags #(
    .RX_DEPTH (RX_DEPTH),
    .TX_DEPTH (TX_DEPTH)
  ) u_levels (
    .rx_level_i (rx_level_i),
    .tx_level_i (tx_level_i),
    .rx_full_o  (rx_full),
    .rx_half_o  (rx_half),
    .tx_half_o  (tx_half)
  );

  assign rx_empty     = (rx_level_i == '0);
  assign ovr_set      = rx_frame_i && rx_full;
  assign rx_replace_o = ovr_set;

  sport_rx_timeout #(
    .TICKS (TMO_TICKS)
  ) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_empty_i (rx_empty),
    .rx_frame_i (rx_frame_i),
    .rx_pop_i   (rx_pop_i),
    .bit_tick_i (bit_tick_i),
    .expire_o   (tmo_expire)
  );

  sport_irq_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ovr_set_i   (ovr_set),
    .tmo_set_i   (tmo_expire),
    .rx_half_i   (rx_half),
    .tx_half_i   (tx_half),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  // R3
  replace_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_replace_o |-> (rx_frame_i && rx_level_i == ($clog2(RX_DEPTH+1))'(RX_DEPTH)));
endmodule

// File: tb/sport_irq_unit_tb.sv
module sport_irq_unit_tb;
  localparam logic [1:0] A_MASK = 2'd0, A_RAW = 2'd1, A_MIS = 2'd2, A_CLR = 2'd3;
  localparam int K_REG = 0, K_IRQ = 1, K_REP = 2;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] rx_level_i = '0;
  logic [3:0] tx_level_i = '0;
  logic       rx_frame_i = 1'b0, rx_pop_i = 1'b0, bit_tick_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       rx_replace_o, irq_o;
  logic       chk_v = 1'b0;
  logic       done = 1'b0;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  sport_irq_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
    .rx_frame_i(rx_frame_i), .rx_pop_i(rx_pop_i), .bit_tick_i(bit_tick_i),
    .rx_replace_o(rx_replace_o),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // monitor
  always @(negedge clk_i) begin
    if (chk_v && sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_REG:   act = reg_rdata_o;
        K_IRQ:   act = {7'd0, irq_o};
        default: act = {7'd0, rx_replace_o};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    cyc();
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic exp_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
    reg_addr_i = a;
    sb_q.push_back('{K_REG, e, tag});
    chk_v = 1'b1;
    cyc();
    chk_v = 1'b0;
  endtask

  task automatic exp_sig(input int k, input logic e, input string tag);
    sb_q.push_back('{k, {7'd0, e}, tag});
    chk_v = 1'b1;
    cyc();
    chk_v = 1'b0;
  endtask

  task automatic ticks(input int n);
    bit_tick_i = 1'b1;
    repeat (n) cyc();
    bit_tick_i = 1'b0;
  endtask

  task automatic frame();
    rx_frame_i = 1'b1; cyc(); rx_frame_i = 1'b0;
  endtask

  task automatic pop();
    rx_pop_i = 1'b1; cyc(); rx_pop_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R2 reset state
    exp_reg(A_MASK, 8'h00, "R2 mask");
    exp_reg(A_RAW,  8'h08, "R2 raw");
    exp_reg(A_MIS,  8'h00, "R2 masked");
    exp_sig(K_IRQ, 1'b0, "R2 irq");
    exp_reg(A_CLR,  8'h00, "R1 clear reads zero");

    // R5 receive half full
    rx_level_i = 4'd4; exp_reg(A_RAW, 8'h0C, "R5 rx=4");
    rx_level_i = 4'd3; exp_reg(A_RAW, 8'h08, "R5 rx=3");
    // R6 transmit half empty
    tx_level_i = 4'd4; exp_reg(A_RAW, 8'h08, "R6 tx=4");
    tx_level_i = 4'd5; exp_reg(A_RAW, 8'h00, "R6 tx=5");

    // R3 overrun
    rx_level_i = 4'd7; frame();
    exp_reg(A_RAW, 8'h04, "R3 no overrun below full");
    rx_level_i = 4'd8; rx_frame_i = 1'b1;
    exp_sig(K_REP, 1'b1, "R3 replace strobe");
    rx_frame_i = 1'b0;
    exp_sig(K_REP, 1'b0, "R3 replace idle");
    exp_reg(A_RAW, 8'h05, "R3 overrun set R1 bit0");

    // R7 sticky and clear
    rx_level_i = 4'd2; exp_reg(A_RAW, 8'h01, "R7 sticky after level drop");
    wr(A_CLR, 8'h00); exp_reg(A_RAW, 8'h01, "R7 clear with zero ignored");
    wr(A_CLR, 8'h01); exp_reg(A_RAW, 8'h00, "R7 clear bit0");
    rx_level_i = 4'd8; rx_frame_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = A_CLR; reg_wdata_i = 8'h01;
    cyc();
    rx_frame_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    exp_reg(A_RAW, 8'h05, "R7 set beats clear");
    rx_level_i = 4'd2; wr(A_CLR, 8'h01);
    exp_reg(A_RAW, 8'h00, "R7 cleared again");

    // R4 timeout
    pop();
    ticks(31); exp_reg(A_RAW, 8'h00, "R4 31 ticks");
    ticks(1);  exp_reg(A_RAW, 8'h02, "R4 32 ticks R1 bit1");
    wr(A_CLR, 8'h02); ticks(10);
    exp_reg(A_RAW, 8'h00, "R7 timeout cleared stays clear");
    pop(); ticks(20); pop(); ticks(31);
    exp_reg(A_RAW, 8'h00, "R4 pop restarts");
    ticks(1); exp_reg(A_RAW, 8'h02, "R4 after restart");
    wr(A_CLR, 8'h02);
    ticks(20); frame(); ticks(31);
    exp_reg(A_RAW, 8'h00, "R4 frame restarts");
    wr(A_CLR, 8'h02);
    rx_level_i = 4'd0; ticks(40);
    exp_reg(A_RAW, 8'h00, "R4 empty holds");
    rx_level_i = 4'd2; ticks(31);
    exp_reg(A_RAW, 8'h00, "R4 empty reset count");
    ticks(1); exp_reg(A_RAW, 8'h02, "R4 expires after empty");
    wr(A_CLR, 8'h02); pop();

    // R8 R9 R10 mask, masked view, irq
    rx_level_i = 4'd4;
    exp_reg(A_RAW, 8'h04, "R5 rx=4 again");
    wr(A_MASK, 8'hFF);
    exp_sig(K_IRQ, 1'b0, "R10 irq one cycle late");
    exp_sig(K_IRQ, 1'b1, "R10 irq asserted");
    exp_reg(A_MASK, 8'h0F, "R8 mask width");
    exp_reg(A_MIS,  8'h04, "R9 masked rx half");
    wr(A_MASK, 8'h08);
    exp_sig(K_IRQ, 1'b1, "R10 irq held one cycle");
    exp_sig(K_IRQ, 1'b0, "R10 irq dropped");
    exp_reg(A_MIS, 8'h00, "R9 masked off");
    tx_level_i = 4'd0;
    exp_reg(A_MIS, 8'h08, "R9 masked tx half");
    exp_sig(K_IRQ, 1'b1, "R10 irq from tx");
    wr(A_MASK, 8'h01);
    rx_level_i = 4'd8; frame();
    exp_reg(A_RAW, 8'h0D, "R3 raw with all rx bits");
    exp_reg(A_MIS, 8'h01, "R9 masked overrun");
    wr(A_MASK, 8'h00); cyc();
    exp_sig(K_IRQ, 1'b0, "R10 irq masked off");
    exp_reg(A_MIS, 8'h00, "R9 mask zero");

    cyc();
    done = 1'b1;
    finish_run();
  end
endmodule